// File: doc/BRIEF.md
# Output Denormalization and Clamp Unit

This unit sits at the end of a pixel pipeline and turns normalized signed fixed-point components into integer codes for a selected output colour depth. Each of the three components is scaled by (2^n − 1)/2^n for an n-bit target, rounded to the nearest code and clamped to the legal range. Because of this scale, an input of exactly 1.0 lands on the top code of each depth, which a plain bit shift would not give.

A small write port holds the configuration: a depth mode (8, 10 or 12 bits, or an unscaled 12-bit pass-through) and a flag that presents the result on a 10-bit output bus. Writes that carry an invalid mode are dropped whole. Pixels move through one register stage, with the valid flag travelling beside the data.

Top module: `denorm_clamp`

## Requirements
- R1: `out_valid` is 0 after reset and equals `in_valid` delayed by exactly one clock; every output register reads 0 after reset.
- R2: After reset the depth mode is 2 (10-bit) and the 10-bit bus flag is 1.
- R3: A write with `reg_wdata[2]` = 0 sets the depth mode to `reg_wdata[1:0]` and the bus flag to `reg_wdata[3]`; a pixel accepted on the clock after the write uses the new settings.
- R4: A write with `reg_wdata[2:0]` in 4..7 changes neither the depth mode nor the bus flag.
- R5: In modes 1, 2 and 3 (n = 8, 10, 12), with input x in units of 2^-FRAC, the code is floor((x·(2^n − 1) + 2^(FRAC−1)) / 2^FRAC), right-aligned and zero-extended in the 12-bit `out_code` field of each channel.
- R6: In mode 0 the value is not scaled: the code is floor((x·2^12 + 2^(FRAC−1)) / 2^FRAC), treated as a 12-bit result.
- R7: A result below 0 gives code 0 and a result above 2^n − 1 gives 2^n − 1 (n = 12 in mode 0).
- R8: An input of exactly 1.0 (2^FRAC) gives 255, 1023 and 4095 in modes 1, 2 and 3.
- R9: With the bus flag set, `out_bus10` carries an 8-bit code shifted left by two, a 10-bit code as is, and a 12-bit code's upper ten bits, with that code's two low bits in `out_lsb`; `out_lsb` is 0 for 8- and 10-bit codes.
- R10: With the bus flag clear, `out_bus10` and `out_lsb` are 0.
- R11: On clocks without `in_valid` the data outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Configuration write strobe |
| reg_wdata | input | 4 | [1:0] depth mode, [2] invalid marker, [3] 10-bit bus flag |
| in_valid | input | 1 | Input pixel valid |
| in_pix | input | CH*IN_W | Signed components, channel 0 in the low bits |
| out_valid | output | 1 | Output pixel valid |
| out_code | output | CH*12 | Right-aligned codes, 12 bits per channel |
| out_bus10 | output | CH*10 | 10-bit bus view per channel |
| out_lsb | output | CH*2 | Low two bits of 12-bit codes per channel |

## Verification
The assertions watch every cycle for the one-clock valid latency, that invalid writes leave the configuration alone, that 8- and 10-bit modes never set code bits above their depth, that a clear bus flag keeps the 10-bit view at zero, and that data holds on idle cycles. The exact rounded values, the clamping of negative and oversized inputs, the full-scale codes and the bus packing at each depth only show through the bench's scoreboard, which predicts every pixel from the arithmetic in the requirements.

// File: rtl/denorm_clamp.sv
module denorm_clamp #(
  parameter int CH   = 3,
  parameter int IN_W = 16,
  parameter int FRAC = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [3:0]         reg_wdata,
  input  logic               in_valid,
  input  logic [CH*IN_W-1:0] in_pix,
  output logic               out_valid,
  output logic [CH*12-1:0]   out_code,
  output logic [CH*10-1:0]   out_bus10,
  output logic [CH*2-1:0]    out_lsb
);
  localparam int W   = IN_W + 14;
  localparam int RND = 1 << (FRAC - 1);

  logic [1:0] mode_q;
  logic       fmt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= 2'd2;
      fmt_q  <= 1'b1;
    end else if (reg_we && !reg_wdata[2]) begin
      mode_q <= reg_wdata[1:0];
      fmt_q  <= reg_wdata[3];
    end

  function automatic logic [11:0] scale(input logic [IN_W-1:0] x, input logic [1:0] m);
    logic signed [W-1:0] xe, t, v, lim;
    int n;
    n   = (m == 2'd1) ? 8 : (m == 2'd2) ? 10 : 12;
    xe  = $signed({{(W-IN_W){x[IN_W-1]}}, x});
    t   = (m == 2'd0) ? (xe <<< 12) : ((xe <<< n) - xe);
    v   = (t + $signed(W'(RND))) >>> FRAC;
    lim = $signed((W'(1) << n) - W'(1));
    if (v < 0)        return 12'd0;
    else if (v > lim) return lim[11:0];
    else              return v[11:0];
  endfunction

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [11:0] code_d;
    logic [9:0]  bus_d;
    logic [1:0]  lsb_d;

    assign code_d = scale(in_pix[c*IN_W +: IN_W], mode_q);

    always_comb begin
      bus_d = '0;
      lsb_d = '0;
      if (fmt_q)
        case (mode_q)
          2'd1:    bus_d = {code_d[7:0], 2'b00};
          2'd2:    bus_d = code_d[9:0];
          default: begin
            bus_d = code_d[11:2];
            lsb_d = code_d[1:0];
          end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        out_code[c*12 +: 12] <= '0;
        out_bus10[c*10 +: 10] <= '0;
        out_lsb[c*2 +: 2]     <= '0;
      end else if (in_valid) begin
        out_code[c*12 +: 12] <= code_d;
        out_bus10[c*10 +: 10] <= bus_d;
        out_lsb[c*2 +: 2]     <= lsb_d;
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
endmodule

// File: rtl/denorm_clamp_chk.sv
module denorm_clamp_chk #(
  parameter int CH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [3:0]       reg_wdata,
  input logic             in_valid,
  input logic             out_valid,
  input logic [1:0]       mode_q,
  input logic             fmt_q,
  input logic [CH*12-1:0] out_code,
  input logic [CH*10-1:0] out_bus10,
  input logic [CH*2-1:0]  out_lsb
);
  logic hi8, hi10;
  always_comb begin
    hi8  = 1'b0;
    hi10 = 1'b0;
    for (int c = 0; c < CH; c++) begin
      hi8  = hi8  | (|out_code[c*12+8 +: 4]);
      hi10 = hi10 | (|out_code[c*12+10 +: 2]);
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_bad_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_wdata[2]) |=> ($stable(mode_q) && $stable(fmt_q)));
  assert_depth8_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_q == 2'd1) |=> !hi8);
  assert_depth10_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_q == 2'd2) |=> !hi10);
  assert_bus_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fmt_q) |=> (out_bus10 == '0 && out_lsb == '0));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_code) && $stable(out_bus10) && $stable(out_lsb)));
endmodule

bind denorm_clamp denorm_clamp_chk #(.CH(CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .in_valid(in_valid), .out_valid(out_valid), .mode_q(mode_q), .fmt_q(fmt_q),
  .out_code(out_code), .out_bus10(out_bus10), .out_lsb(out_lsb)
);

// File: tb/denorm_clamp_tb.sv
module denorm_clamp_tb;
  localparam int CH = 3, IN_W = 16, FRAC = 12;

  logic clk = 0, rst_n = 0, reg_we = 0, in_valid = 0;
  logic [3:0] reg_wdata = '0;
  logic [CH*IN_W-1:0] in_pix = '0;
  logic out_valid;
  logic [CH*12-1:0] out_code;
  logic [CH*10-1:0] out_bus10;
  logic [CH*2-1:0] out_lsb;

  denorm_clamp #(.CH(CH), .IN_W(IN_W), .FRAC(FRAC)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .in_valid(in_valid), .in_pix(in_pix), .out_valid(out_valid),
    .out_code(out_code), .out_bus10(out_bus10), .out_lsb(out_lsb));

  always #5 clk = ~clk;

  typedef struct {
    logic [CH*12-1:0] code;
    logic [CH*10-1:0] bus;
    logic [CH*2-1:0]  lsb;
    string            tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  int m_mode = 2;
  bit m_fmt = 1;
  logic [CH*12-1:0] last_code;
  logic [CH*10-1:0] last_bus;
  logic [CH*2-1:0]  last_lsb;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int model(input int x, input int m);
    longint t, v;
    int n;
    n = (m == 1) ? 8 : (m == 2) ? 10 : 12;
    t = (m == 0) ? longint'(x) * 4096 : longint'(x) * ((1 << n) - 1);
    v = (t + (1 << (FRAC - 1))) >>> FRAC;
    if (v < 0) v = 0;
    if (v > (1 << n) - 1) v = (1 << n) - 1;
    return int'(v);
  endfunction

  task automatic wr(input logic [3:0] d);
    @(negedge clk);
    reg_we = 1; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (!d[2]) begin m_mode = d[1:0]; m_fmt = d[3]; end
  endtask

  task automatic send(input int x0, input int x1, input int x2, input string tag);
    exp_t e;
    int xs[3];
    xs[0] = x0; xs[1] = x1; xs[2] = x2;
    e.tag = tag;
    for (int c = 0; c < CH; c++) begin
      int cd;
      logic [9:0] b;
      logic [1:0] l;
      cd = model(xs[c], m_mode);
      b = '0; l = '0;
      if (m_fmt) begin
        if (m_mode == 1)      b = 10'(cd << 2);
        else if (m_mode == 2) b = 10'(cd);
        else begin b = 10'(cd >> 2); l = 2'(cd); end
      end
      e.code[c*12 +: 12] = 12'(cd);
      e.bus[c*10 +: 10] = b;
      e.lsb[c*2 +: 2] = l;
      in_pix[c*IN_W +: IN_W] = IN_W'(xs[c]);
    end
    q.push_back(e);
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (q.size() == 0) check(0, "R1", "unexpected out_valid", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(out_code == e.code, e.tag, "code", longint'(out_code), longint'(e.code));
          check(out_bus10 == e.bus && out_lsb == e.lsb, e.tag, "bus10/lsb",
                longint'({out_bus10, out_lsb}), longint'({e.bus, e.lsb}));
          last_code = e.code; last_bus = e.bus; last_lsb = e.lsb;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(0, "watchdog", "timeout", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_code == '0 && out_bus10 == '0 && out_lsb == '0,
          "R1", "reset outputs", longint'(out_code), 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R1", "idle valid", out_valid, 0);
    // R2: default 10-bit mode with bus flag set
    send(4096, 2048, 0, "R2");
    // R8: full scale in each depth
    send(4096, 4096, 4096, "R8");
    wr(4'b1001); send(4096, 2048, 1000, "R8");
    wr(4'b1011); send(4096, 2048, 1000, "R8");
    // R5: rounding in several depths, back-to-back pixels
    wr(4'b1001); send(17, 1234, 3000, "R5"); send(8, 7, 9, "R5");
    wr(4'b1010); send(1, 2, 3, "R5"); send(333, 2047, 4095, "R5");
    wr(4'b1011); send(5, 4001, 123, "R5");
    // R7: clamping of negative and oversized inputs
    wr(4'b1001); send(-5, 8000, -32768, "R7");
    wr(4'b1011); send(32767, -1, 4097, "R7");
    // R6: pass-through mode
    wr(4'b1000); send(4095, 100, 4096, "R6"); send(-3, 2000, 7, "R6");
    // R9: packing per depth
    wr(4'b1011); send(1, 2, 3071, "R9");
    wr(4'b1001); send(1000, 3000, 4000, "R9");
    // R10: bus flag cleared
    wr(4'b0010); send(4096, 1000, 3000, "R10");
    wr(4'b0011); send(4096, 1001, 3001, "R10");
    // R3: immediate use of new setting on the next pixel
    wr(4'b1001); send(2048, 2048, 2048, "R3");
    // R4: invalid writes ignored
    wr(4'b0100); send(2048, 4096, 100, "R4");
    wr(4'b1111); send(300, 4096, 99, "R4");
    wr(4'b0110); send(4096, 10, 20, "R4");
    repeat (4) @(negedge clk);
    // R11: outputs held while idle
    check(out_code == last_code && out_bus10 == last_bus && out_lsb == last_lsb,
          "R11", "hold", longint'(out_code), longint'(last_code));
    check(q.size() == 0, "R1", "pending items", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule